// File: doc/BRIEF.md
# Time-Shared Pipelined Tile Link

This block carries several logical values from one source tile to one destination tile over a single physical channel. The channel is a chain of short register segments, and each segment is crossed in one clock cycle. A value in flight occupies one segment per cycle, so a new value can enter the channel on every cycle. Which logical value owns the channel in a given cycle is fixed when the design is built, by a slot table. The source tile's controller presents its current slot number, and the link has no arbitration at run time.

At the source end, a multiplexer steered by the slot number puts the chosen value on the channel. The slot number travels down a parallel delay line beside the data. At the far end, the delayed slot number is decoded against the same table, and the arriving word is written into the destination register of its own logical value. A slot can be marked as carrying nothing. A link that crosses an intermediate tile simply has more segments. The segment count, the number of logical values, the data width and the table are all parameters. There is no flow control: the schedule guarantees that the destination is ready, so the link has neither valid nor ready pins.

Top module: `vw_link`

## Requirements
- R1: A synchronous reset clears every destination register and every segment of the channel. For the HOPS cycles after reset is released, no destination register takes a value that was in flight before the reset.
- R2: A value presented with slot s appears in its destination register exactly HOPS rising edges later (HOPS = 3 by default), and not earlier.
- R3: A slot s in the range 0 to NSLOT-1 routes the value of logical input SCHED[s] to destination register SCHED[s]. The table holds one IW-bit field per slot, and the field of slot 0 is at the least significant end. The default table maps slots 0 to 5 onto values 2, 0, idle, 3, 1 and 0.
- R4: A slot whose table entry equals NVAL (the idle code, which is slot 2 by default) changes no destination register.
- R5: A new logical value can enter the link on every cycle. Back-to-back slots that name different values each deliver their own data.
- R6: A slot number of NSLOT or more is treated as idle and changes no destination register.
- R7: A destination register holds its value until its own slot delivers a new one, and at most one destination register changes on any edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| slot_i | input | SW = clog2(NSLOT) | Current slot number from the source controller |
| src_i | input | NVAL*W | Logical source values, value v at bits [v*W +: W] |
| dst_o | output | NVAL*W | Destination registers, value v at bits [v*W +: W] |

## Verification
A short table of vectors walks every slot number once, including the idle slot and both out-of-range numbers. Each logical value carries its own distinct data, so a routing error or an off-by-one in the delay shows up as the wrong byte in the wrong lane. Many rounds follow in which the slots run back to back in order and the data is random. These rounds separate correct latency and full throughput from a pipeline that drops or repeats words. Directed runs then apply only idle or out-of-range slots, and then only one slot repeated, to confirm that the untouched lanes hold their values. A reset in the middle of traffic, followed by idle slots, shows whether any stale segment data leaks into a destination register.

// File: rtl/vw_pkg.sv
`timescale 1ns/1ps
package vw_pkg;
  // Width of the table vector accepted by the lookup helper.
  localparam int unsigned VW_TBL_BITS = 256;

  // Returns the IW-bit field of entry s of a packed slot table.
  function automatic int unsigned vw_lookup(input logic [VW_TBL_BITS-1:0] tbl,
                                            input int unsigned iw,
                                            input int unsigned s);
    logic [VW_TBL_BITS-1:0] sh;
    sh = tbl >> (s * iw);
    return 32'(sh[31:0] & ((32'd1 << iw) - 32'd1));
  endfunction
endpackage

// File: rtl/vw_src_sel.sv
`timescale 1ns/1ps
module vw_src_sel #(
  parameter int W     = 8,
  parameter int NVAL  = 4,
  parameter int NSLOT = 6,
  parameter int IW    = 3,
  parameter int SW    = 3,
  parameter logic [NSLOT*IW-1:0] SCHED = '0
) (
  input  logic [SW-1:0]     slot_i,
  input  logic [NVAL*W-1:0] src_i,
  output logic [W-1:0]      data_o
);
  int code;

  always_comb begin
    code = NVAL;
    if (32'(slot_i) < NSLOT)
      code = int'(vw_pkg::vw_lookup(vw_pkg::VW_TBL_BITS'(SCHED), IW, 32'(slot_i)));
    data_o = '0;
    for (int v = 0; v < NVAL; v++)
      if (code == v) data_o = src_i[v*W +: W];
  end
endmodule

// File: rtl/vw_pipe.sv
`timescale 1ns/1ps
module vw_pipe #(
  parameter int WD    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WD-1:0] d,
  output logic [WD-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [WD-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/vw_dst_cap.sv
`timescale 1ns/1ps
module vw_dst_cap #(
  parameter int W     = 8,
  parameter int NVAL  = 4,
  parameter int NSLOT = 6,
  parameter int IW    = 3,
  parameter int SW    = 3,
  parameter logic [NSLOT*IW-1:0] SCHED = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SW-1:0]     slot_d,
  input  logic [W-1:0]      data_d,
  output logic [NVAL*W-1:0] dst_o,
  output logic              cap_en,
  output logic [NVAL-1:0]   wr_vec
);
  int code;

  always_comb begin
    code = NVAL;
    if (32'(slot_d) < NSLOT)
      code = int'(vw_pkg::vw_lookup(vw_pkg::VW_TBL_BITS'(SCHED), IW, 32'(slot_d)));
  end

  assign cap_en = (code < NVAL);

  generate
    for (genvar v = 0; v < NVAL; v++) begin : g_lane
      assign wr_vec[v] = cap_en && (code == v);
      always_ff @(posedge clk) begin
        if (rst)            dst_o[v*W +: W] <= '0;
        else if (wr_vec[v]) dst_o[v*W +: W] <= data_d;
      end
    end
  endgenerate
endmodule

// File: rtl/vw_link.sv
`timescale 1ns/1ps
module vw_link #(
  parameter int W     = 8,
  parameter int NVAL  = 4,
  parameter int NSLOT = 6,
  parameter int HOPS  = 3,
  // One field per slot, slot 0 lowest: 2,0,idle,3,1,0
  parameter logic [NSLOT*$clog2(NVAL+1)-1:0] SCHED = 18'o013402
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic [$clog2(NSLOT)-1:0]   slot_i,
  input  logic [NVAL*W-1:0]          src_i,
  output logic [NVAL*W-1:0]          dst_o
);
  localparam int IW    = $clog2(NVAL + 1);
  localparam int SW    = $clog2(NSLOT);
  localparam int DEPTH = HOPS - 1;  // capture register is the last hop

  logic [W-1:0]    ch_in, ch_out;
  logic [SW-1:0]   slot_out;
  logic            cap_en;
  logic [NVAL-1:0] wr_vec;

  vw_src_sel #(.W(W), .NVAL(NVAL), .NSLOT(NSLOT), .IW(IW), .SW(SW), .SCHED(SCHED))
    u_sel (.slot_i(slot_i), .src_i(src_i), .data_o(ch_in));

  vw_pipe #(.WD(W), .DEPTH(DEPTH))
    u_data_seg (.clk(clk_i), .rst(rst_i), .d(ch_in), .q(ch_out));

  vw_pipe #(.WD(SW), .DEPTH(DEPTH))
    u_slot_seg (.clk(clk_i), .rst(rst_i), .d(slot_i), .q(slot_out));

  vw_dst_cap #(.W(W), .NVAL(NVAL), .NSLOT(NSLOT), .IW(IW), .SW(SW), .SCHED(SCHED))
    u_cap (.clk(clk_i), .rst(rst_i), .slot_d(slot_out), .data_d(ch_out),
           .dst_o(dst_o), .cap_en(cap_en), .wr_vec(wr_vec));
endmodule

// File: rtl/vw_link_chk.sv
`timescale 1ns/1ps
module vw_link_chk #(
  parameter int W    = 8,
  parameter int NVAL = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_en,
  input logic [NVAL-1:0]   wr_vec,
  input logic [NVAL*W-1:0] dst
);
  logic [NVAL*W-1:0] prev;
  logic [NVAL-1:0]   chg;

  always_ff @(posedge clk) prev <= dst;

  always_comb
    for (int v = 0; v < NVAL; v++) chg[v] = (dst[v*W +: W] != prev[v*W +: W]);

  AST_RESET_CLEAR: assert property (@(posedge clk) $fell(rst) |-> dst == '0)
    else $error("reset left a destination nonzero"); // R1
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_vec))
    else $error("more than one lane write enable"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !cap_en |=> $stable(dst))
    else $error("destination changed without a capture"); // R4
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst) $countones(chg) <= 1)
    else $error("several destinations changed on one edge"); // R7
endmodule

bind vw_link vw_link_chk #(.W(W), .NVAL(NVAL)) u_chk (
  .clk(clk_i), .rst(rst_i), .cap_en(cap_en), .wr_vec(wr_vec), .dst(dst_o));

// File: tb/tb_vw_link.sv
`timescale 1ns/1ps
module tb_vw_link;
  localparam int W = 8, NVAL = 4, NSLOT = 6, HOPS = 3;
  localparam logic [2:0] VSLOT [12] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5,
                                        3'd6, 3'd7, 3'd5, 3'd0, 3'd2, 3'd3};
  localparam logic [7:0] VDATA [12] = '{8'h10, 8'h24, 8'h38, 8'h4C, 8'h60, 8'h74,
                                        8'h88, 8'h9C, 8'hB0, 8'hC4, 8'hD8, 8'hEC};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  slot = 3'd2;
  logic [31:0] src = '0;
  logic [31:0] dst;

  int checks = 0, errors = 0, n = 0;
  bit done = 0;
  logic [7:0]  exp_q [NVAL];
  logic [2:0]  hs [8];
  logic [31:0] hv [8];

  always #2 clk = ~clk;  // 250 MHz

  vw_link dut (.clk_i(clk), .rst_i(rst), .slot_i(slot), .src_i(src), .dst_o(dst));

  // Expected routing from R3: slot -> lane, -1 for idle or out of range (R4, R6)
  function automatic int bdest(input logic [2:0] s);
    case (s)
      3'd0: return 2;
      3'd1: return 0;
      3'd3: return 3;
      3'd4: return 1;
      3'd5: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic check(input logic [7:0] a, input logic [7:0] e, input string tag);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic cycle(input logic [2:0] s, input logic [31:0] v, input string tag);
    @(negedge clk);
    if (n >= HOPS) begin
      int idx = (n - HOPS) % 8;
      int d = bdest(hs[idx]);
      if (d >= 0) exp_q[d] = hv[idx][d*8 +: 8];
    end
    for (int l = 0; l < NVAL; l++) check(dst[l*8 +: 8], exp_q[l], tag);
    slot = s; src = v;
    hs[n % 8] = s; hv[n % 8] = v;
    n++;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; slot = 3'd2; src = 32'hA5A5A5A5;
    for (int i = 0; i < 8; i++) hs[i] = 3'd2;
    for (int l = 0; l < NVAL; l++) exp_q[l] = '0;
    @(negedge clk);
    @(negedge clk);
    for (int l = 0; l < NVAL; l++) check(dst[l*8 +: 8], 8'h00, tag);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin hs[i] = 3'd2; hv[i] = '0; end
    for (int l = 0; l < NVAL; l++) exp_q[l] = '0;
    // R1: reset state
    do_reset("R1 reset state");
    // R3 R4 R6: vector table, one distinct byte per lane
    for (int i = 0; i < 12; i++)
      cycle(VSLOT[i], {VDATA[i] + 8'd3, VDATA[i] + 8'd2, VDATA[i] + 8'd1, VDATA[i]},
            "R3 vector");
    // R2 R5: back-to-back slots, random data
    for (int r = 0; r < 40; r++)
      for (int k = 0; k < NSLOT; k++)
        cycle(3'(k), $urandom, "R2 R5 stream");
    // R6: out-of-range slots must not capture
    for (int k = 0; k < 8; k++)
      cycle((k % 2) ? 3'd7 : 3'd6, $urandom, "R6 out of range");
    // R4: idle slot must not capture
    for (int k = 0; k < 6; k++)
      cycle(3'd2, $urandom, "R4 idle slot");
    // R7: only lane 0 is written, others hold
    for (int k = 0; k < 8; k++)
      cycle(3'd1, $urandom, "R7 hold");
    // R1: reset in mid traffic, no stale data afterwards
    cycle(3'd3, 32'h77665544, "R7 hold");
    cycle(3'd0, 32'h33221100, "R7 hold");
    do_reset("R1 mid reset");
    for (int k = 0; k < HOPS + 2; k++)
      cycle(3'd2, 32'hFFFFFFFF, "R1 flushed");
    for (int k = 0; k < 3; k++)
      cycle(3'd5, 32'h0000005A, "R2 after reset");
    for (int k = 0; k < HOPS + 1; k++)
      cycle(3'd2, '0, "R2 drain");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule